// File: doc/BRIEF.md
# Magic-Kick Countdown Watchdog Timer

This block is a memory-mapped watchdog. Software picks one of sixteen power-of-two timeout periods, turns the watchdog on, and from then on has to restart it from time to time. It restarts the counter by writing a fixed key word to the restart register. A down-counter decrements once per clock while the watchdog is on. If the counter reaches zero, the block does one of two things. In direct mode it raises a system reset request at once. In warning mode it raises an interrupt first, and it requests a reset only if that interrupt is still pending at the next expiry.

Software cannot turn the watchdog off again. Only the synchronous reset of the block stops it. The register port is a simple 32-bit read/write port with registered read data, which appears one clock after the read strobe. The timeout of code n is 2^(TOP_BASE+n) cycles, and TOP_BASE is 16 by default. The very first load after enabling uses a separate initial code. Every later restart uses the running code.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `irq`, `sys_rst_req` and `rd_data` are 0, and the control, range and count registers all read back as 0.
- R2: Writing control (0x00) with bit 0 = 1 while the watchdog is off loads the counter with 2^(TOP_BASE+INIT)-1, where INIT is range bits [7:4]. The counter then decrements by one per clock. Its value, as it stood before the read edge, is returned by a read of 0x08.
- R3: Once enabled, the enable stays set. Writing control with bit 0 = 0 leaves control bit 0 reading as 1, and the counter keeps running.
- R4: Writing exactly 0x00000076 to the restart register (0x0C) while enabled reloads the counter with 2^(TOP_BASE+TOP)-1, where TOP is range bits [3:0]. Any other value written there leaves the count unchanged.
- R5: A write to the range register (0x04) while enabled stores the value and reloads the counter with 2^(TOP_BASE+new TOP)-1. While disabled, the write only stores the value, which reads back as written in bits [7:0].
- R6: With control bit 1 = 0, an expiry (counter at 0 while enabled) drives `sys_rst_req` high for exactly RST_CYC consecutive cycles, starting the cycle after the expiry edge. The counter reloads with the TOP period.
- R7: With control bit 1 = 1, an expiry with no interrupt pending sets `irq` and reloads the counter, with no reset request. An expiry while `irq` is still pending raises the `sys_rst_req` pulse.
- R8: A read of 0x14 returns the interrupt flag in bit 0 and clears `irq`, and it does not reload the counter.
- R9: While disabled, the counter holds its value, restart-key writes have no effect, and neither `irq` nor `sys_rst_req` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Pending expiry interrupt flag |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The counter is exercised in several situations:
- while disabled, with range and key writes that must not start it;
- after the enable edge, where the initial code must be used rather than the running code;
- under a correct key, a wrong key and a range write, which separates the three reload sources.

Direct and warning modes are both run to expiry. In warning mode the interrupt is cleared once and then left pending, which distinguishes a cleared first expiry from a second expiry that must reset. A behavioural model is compared with the outputs on every cycle, and the reset pulse width is measured separately.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_RANGE = 8'h04;
  localparam logic [7:0] A_COUNT = 8'h08;
  localparam logic [7:0] A_KICK  = 8'h0C;
  localparam logic [7:0] A_ICLR  = 8'h14;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic [3:0] init_code;
    logic [3:0] run_code;
  } range_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              irq_flag,
  output logic [DATA_W-1:0] rd_data,
  output logic              en,
  output logic              mode,
  output logic [3:0]        run_code,
  output logic              load,
  output logic [3:0]        load_code,
  output logic              iclr
);
  range_t range_q;
  logic   sel_ctrl, sel_range, sel_kick;

  assign sel_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign sel_range = wr_en && (addr == ADDR_W'(A_RANGE));
  assign sel_kick  = wr_en && (addr == ADDR_W'(A_KICK));
  assign iclr      = rd_en && (addr == ADDR_W'(A_ICLR));
  assign run_code  = range_q.run_code;

  always_comb begin
    load      = 1'b0;
    load_code = range_q.run_code;
    if (sel_ctrl && wr_data[0] && !en) begin
      load      = 1'b1;
      load_code = range_q.init_code;
    end else if (sel_range && en) begin
      load      = 1'b1;
      load_code = wr_data[3:0];
    end else if (sel_kick && en && (wr_data == DATA_W'(KICK_KEY))) begin
      load      = 1'b1;
      load_code = range_q.run_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      mode    <= 1'b0;
      range_q <= '0;
    end else begin
      if (sel_ctrl) begin
        en   <= en | wr_data[0];
        mode <= wr_data[1];
      end
      if (sel_range) range_q <= range_t'(wr_data[7:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (addr == ADDR_W'(A_CTRL))       rd_data <= {{(DATA_W-2){1'b0}}, mode, en};
      else if (addr == ADDR_W'(A_RANGE)) rd_data <= {{(DATA_W-8){1'b0}}, range_q};
      else if (addr == ADDR_W'(A_COUNT)) rd_data <= DATA_W'(cnt);
      else if (addr == ADDR_W'(A_ICLR))  rd_data <= {{(DATA_W-1){1'b0}}, irq_flag};
      else                               rd_data <= '0;
    end
  end

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (rst) en |=> en);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TOP_BASE = 16,
  parameter int CNT_W    = TOP_BASE + 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode,
  input  logic [3:0]       run_code,
  input  logic             load,
  input  logic [3:0]       load_code,
  input  logic             iclr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq_flag,
  output logic             fire
);
  logic             expire;
  logic [CNT_W-1:0] load_val, reload_val;

  function automatic logic [CNT_W-1:0] period_m1(input logic [3:0] code);
    return (CNT_W'(1) << (TOP_BASE + int'(code))) - CNT_W'(1);
  endfunction

  assign load_val   = period_m1(load_code);
  assign reload_val = period_m1(run_code);
  assign expire     = en && !load && (cnt == '0);
  assign fire       = expire && (!mode || irq_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en) begin
      if (cnt == '0) cnt <= reload_val;
      else           cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 irq_flag <= 1'b0;
    else if (expire && mode) irq_flag <= 1'b1;
    else if (iclr)           irq_flag <= 1'b0;
  end

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt));
  // R7
  first_expiry_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && mode && !irq_flag) |=> (irq_flag && cnt == $past(reload_val)));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int RST_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic req
);
  generate
    if (RST_CYC <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= fire;
      end
    end else begin : g_multi
      localparam int PW = $clog2(RST_CYC + 1);
      logic [PW-1:0] left;
      always_ff @(posedge clk) begin
        if (rst) begin
          req  <= 1'b0;
          left <= '0;
        end else if (fire) begin
          req  <= 1'b1;
          left <= PW'(RST_CYC - 1);
        end else if (req) begin
          if (left == '0) req <= 1'b0;
          else            left <= left - PW'(1);
        end
      end
      // R6
      pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |=> req);
    end
  endgenerate

  // R6
  fire_to_req_chk: assert property (@(posedge clk) disable iff (rst) fire |=> req);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TOP_BASE = 16,
  parameter int RST_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam int CNT_W = TOP_BASE + 16;

  logic             en, mode, load, iclr, fire;
  logic [3:0]       run_code, load_code;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .cnt(cnt), .irq_flag(irq), .rd_data(rd_data), .en(en),
    .mode(mode), .run_code(run_code), .load(load), .load_code(load_code),
    .iclr(iclr)
  );

  wdog_counter #(.TOP_BASE(TOP_BASE), .CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .run_code(run_code),
    .load(load), .load_code(load_code), .iclr(iclr), .cnt(cnt),
    .irq_flag(irq), .fire(fire)
  );

  wdog_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .req(sys_rst_req)
  );

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sys_rst_req && !irq));
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam int E  = 4;
  localparam int RC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq, sys_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_timer #(.ADDR_W(8), .DATA_W(32), .TOP_BASE(E), .RST_CYC(RC)) u_wdog_timer (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  // behavioural reference
  bit          m_en, m_mode, m_flag;
  int          m_top, m_init, m_rem;
  longint      m_cnt;
  logic [31:0] m_rd;

  function automatic longint per(int code);
    return (longint'(1) << (E + code)) - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mode = 0; m_flag = 0; m_top = 0; m_init = 0;
      m_rem = 0; m_cnt = 0; m_rd = 0;
    end else begin
      bit en0, mode0, flag0, ld, ex;
      int code;
      en0 = m_en; mode0 = m_mode; flag0 = m_flag; ld = 0; code = 0;
      if (rd_en) begin
        case (addr)
          8'h00: m_rd = {30'd0, m_mode, m_en};
          8'h04: m_rd = 32'(m_init * 16 + m_top);
          8'h08: m_rd = 32'(m_cnt);
          8'h14: m_rd = {31'd0, m_flag};
          default: m_rd = 0;
        endcase
      end
      if (wr_en && addr == 8'h00) begin
        if (!en0 && wr_data[0]) begin ld = 1; code = m_init; end
        if (wr_data[0]) m_en = 1;
        m_mode = wr_data[1];
      end
      if (wr_en && addr == 8'h04) begin
        m_top = int'(wr_data[3:0]); m_init = int'(wr_data[7:4]);
        if (en0) begin ld = 1; code = m_top; end
      end
      if (wr_en && addr == 8'h0C && wr_data == 32'h76 && en0) begin
        ld = 1; code = m_top;
      end
      ex = !ld && en0 && m_cnt == 0;
      if (ld) m_cnt = per(code);
      else if (en0) m_cnt = (m_cnt == 0) ? per(m_top) : m_cnt - 1;
      if (ex && mode0) m_flag = 1;
      else if (rd_en && addr == 8'h14) m_flag = 0;
      if (ex && (!mode0 || flag0)) m_rem = RC;
      else if (m_rem > 0) m_rem = m_rem - 1;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 sys_rst_req", longint'(sys_rst_req), longint'(m_rem > 0));
      chk("R7 irq", longint'(irq), longint'(m_flag));
      chk("R2 rd_data", longint'(rd_data), longint'(m_rd));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int width, waited;
    bit found;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", longint'(irq), 0);
    chk("R1 sys_rst_req", longint'(sys_rst_req), 0);
    rd(8'h00, v); chk("R1 ctrl", longint'(v), 0);
    rd(8'h04, v); chk("R1 range", longint'(v), 0);
    rd(8'h08, v); chk("R1 count", longint'(v), 0);
    // R9 disabled: range store, key ignored, counter holds
    wr(8'h04, 32'h10);
    wr(8'h0C, 32'h76);
    repeat (20) @(negedge clk);
    rd(8'h08, v); chk("R9 count held", longint'(v), 0);
    rd(8'h04, v); chk("R5 range stored while off", longint'(v), 32'h10);
    chk("R9 no reset", longint'(sys_rst_req), 0);
    // R2 enable loads initial-code period
    wr(8'h00, 32'h1);
    rd(8'h08, v); chk("R2 first load", longint'(v), 31);
    rd(8'h08, v); chk("R2 decrement", longint'(v), 30);
    // R3 sticky enable
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R3 enable sticky", longint'(v), 1);
    // R4 key restart
    wr(8'h0C, 32'h76);
    rd(8'h08, v); chk("R4 key reload", longint'(v), 15);
    wr(8'h0C, 32'h55);
    rd(8'h08, v); chk("R4 wrong key ignored", longint'(v), 13);
    wr(8'h0C, 32'h176);
    rd(8'h08, v); chk("R4 wide wrong key ignored", longint'(v), 11);
    // R6 direct mode expiry pulse
    found = 0;
    for (int i = 0; i < 40 && !found; i++) begin
      @(negedge clk);
      if (sys_rst_req) found = 1;
    end
    chk("R6 pulse seen", longint'(found), 1);
    width = 1;
    while (sys_rst_req && width < 100) begin @(negedge clk); if (sys_rst_req) width++; end
    chk("R6 pulse width", width, RC);
    // R5 range write while running restarts with new TOP
    wr(8'h04, 32'h01);
    rd(8'h08, v); chk("R5 range reload", longint'(v), 31);
    // R7 warning mode
    wr(8'h00, 32'h3);
    found = 0;
    for (int i = 0; i < 80 && !found; i++) begin
      @(negedge clk);
      if (irq) found = 1;
    end
    chk("R7 irq raised", longint'(found), 1);
    chk("R7 no reset at first expiry", longint'(sys_rst_req), 0);
    // R8 clear by read
    rd(8'h14, v); chk("R8 flag readback", longint'(v), 1);
    chk("R8 irq cleared", longint'(irq), 0);
    rd(8'h08, v); chk("R8 count not restarted", longint'(v), 30);
    // R7 second expiry with pending flag resets
    found = 0;
    for (int i = 0; i < 80 && !found; i++) begin
      @(negedge clk);
      if (irq) found = 1;
    end
    chk("R7 irq raised again", longint'(found), 1);
    chk("R7 no reset on cleared flag", longint'(sys_rst_req), 0);
    found = 0; waited = 0;
    for (int i = 0; i < 80 && !found; i++) begin
      @(negedge clk);
      waited++;
      if (sys_rst_req) found = 1;
    end
    chk("R7 reset on pending flag", longint'(found), 1);
    chk("R7 second expiry spacing", waited, 32);
    chk("R7 flag still pending", longint'(irq), 1);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule